// File: doc/BRIEF.md
# Asynchronous HDLC Framing Engine

This block turns host frames into a byte stream for a UART and turns a UART byte stream back into host frames, using asynchronous HDLC framing. On the transmit side the host supplies the complete frame body, one byte per handshake, and marks its final byte. The engine brackets the body with flag octets, escapes reserved octets and appends a frame check sequence that it computes on the fly. The receive side hunts for flags and removes escapes. It drops frames addressed to another station, checks the frame check sequence and reports one status result per frame. The check bytes are either stripped or handed on to the host, as configured.

Every stream uses valid/ready handshakes, and every data output is registered. The flag octet is 0x7E and the escape octet is 0x7D. The check sequence is CRC-16 with the reflected polynomial 0x8408 and a preset of 0xFFFF. It is sent complemented, low byte first, and a correct received frame leaves the residue 0xF0B8. The receiver keeps the last three decoded bytes in a small window, so it can mark the final data byte once the closing flag shows where the frame ends.

Top module: `ahdlc_engine`

## Requirements
- R1: A transmitted frame starts with one 0x7E flag, sent when the first body byte is offered, and ends with one 0x7E flag after the check bytes.
- R2: In the transmit stream, every body or check byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20, and every other byte is sent unchanged.
- R3: After the body, the transmitter sends the complement of the CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) computed over the unescaped body bytes, low byte first.
- R4: While an output valid is high and its ready is low, the output data (and, on receive, the last marker) stays unchanged until it is accepted.
- R5: The receiver replaces each pair of 0x7D and X, where X is not a flag, with X XOR 0x20 before any further processing.
- R6: The receiver accepts a frame only when its first decoded byte equals `cfg_addr` or 0xFF. Any other frame produces no output byte and no status.
- R7: With `cfg_fcs_pass`=0, an accepted frame of at least three decoded bytes delivers every byte except the two check bytes, with `rx_out_last` set on the final one. A status pulse comes with `rx_stat_ok`=1 when the residue over all decoded bytes is 0xF0B8.
- R8: With `cfg_fcs_pass`=1, the two received check bytes follow the data bytes in received order, and `rx_out_last` is set on the second check byte.
- R9: A frame whose residue is not 0xF0B8 still delivers its bytes, but its status pulse carries `rx_stat_ok`=0.
- R10: A frame of one or two decoded bytes gives a status pulse with `rx_stat_ok`=0 and no output bytes. Two adjacent flags give nothing. A status pulse lasts one cycle.
- R11: An escape octet followed directly by a flag aborts the frame with a status pulse carrying `rx_stat_ok`=0. The flag then opens the next frame, which is received normally.
- R12: After reset, no output valid and no status pulse is asserted, and the transmit input is not ready until a frame is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Station address accepted by the receiver |
| cfg_fcs_pass | input | 1 | 1: pass the received check bytes to the host |
| tx_in_data | input | 8 | Frame body byte from the host |
| tx_in_valid | input | 1 | Body byte valid |
| tx_in_last | input | 1 | Marks the final body byte |
| tx_in_ready | output | 1 | Engine accepts the body byte |
| tx_out_data | output | 8 | Encoded byte to the UART transmit FIFO |
| tx_out_valid | output | 1 | Encoded byte valid |
| tx_out_ready | input | 1 | Transmit FIFO accepts the byte |
| rx_in_data | input | 8 | Raw byte from the UART receive FIFO |
| rx_in_valid | input | 1 | Raw byte valid |
| rx_in_ready | output | 1 | Engine accepts the raw byte |
| rx_out_data | output | 8 | Decoded byte to the host |
| rx_out_last | output | 1 | Final byte of the frame |
| rx_out_valid | output | 1 | Decoded byte valid |
| rx_out_ready | input | 1 | Host accepts the decoded byte |
| rx_stat_valid | output | 1 | One-cycle end-of-frame status pulse |
| rx_stat_ok | output | 1 | Frame check result, meaningful with the pulse |

## Verification
The hardest situations to reach from the ports are a check byte that itself needs escaping, and an abort that arrives after some bytes of the frame have already left the window. The first cannot be chosen directly, because the check bytes follow from the body. The bench therefore sweeps all 256 single-byte bodies through the transmitter and all 256 second bytes through the receiver. Several of those frames produce a check byte of 0x7E or 0x7D. The abort case is built by hand: a stream of four decoded bytes forces one byte out early, then an escape and a flag end the frame, and a good frame follows to show that the receiver resynchronizes.

// File: rtl/ahdlc_pkg.sv
package ahdlc_pkg;
  localparam int OCT_W = 8;
  localparam int FCS_BYTES = 2;
  localparam logic [7:0] OCT_FLAG  = 8'h7E;
  localparam logic [7:0] OCT_ESC   = 8'h7D;
  localparam logic [7:0] OCT_XMASK = 8'h20;
  localparam logic [7:0] OCT_BCAST = 8'hFF;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam logic [15:0] CRC_POLYR = 16'h8408;
  localparam logic [15:0] CRC_GOOD  = 16'hF0B8;

  typedef enum logic [2:0] {TX_IDLE, TX_BODY, TX_FCS0, TX_FCS1, TX_CLOSE} tx_st_t;
  typedef enum logic [1:0] {RX_HUNT, RX_FRAME, RX_DROP, RX_FLUSH} rx_st_t;

  // one byte of reflected CRC-16, least significant bit first
  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLYR) : (r >> 1);
    return r;
  endfunction

  function automatic logic needs_esc(input logic [7:0] b);
    return (b == OCT_FLAG) || (b == OCT_ESC);
  endfunction
endpackage

// File: rtl/ahdlc_oreg.sv
module ahdlc_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (free) begin
      valid <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/ahdlc_tx.sv
module ahdlc_tx
  import ahdlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic [OCT_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  tx_st_t           st, esc_next, after;
  logic [15:0]      crc;
  logic             esc_pend;
  logic [OCT_W-1:0] esc_byte, src, obyte;
  logic             src_avail, free, load;

  ahdlc_oreg #(.W(OCT_W)) u_oreg (
    .clk(clk), .rst(rst), .load(load), .din(obyte), .ready(out_ready),
    .valid(out_valid), .dout(out_data), .free(free)
  );

  always_comb begin
    src = in_data;
    src_avail = 1'b0;
    after = TX_CLOSE;
    case (st)
      TX_BODY: begin src_avail = in_valid; after = in_last ? TX_FCS0 : TX_BODY; end
      TX_FCS0: begin src = ~crc[7:0];  src_avail = 1'b1; after = TX_FCS1; end
      TX_FCS1: begin src = ~crc[15:8]; src_avail = 1'b1; after = TX_CLOSE; end
      default: ;
    endcase
  end

  assign in_ready = (st == TX_BODY) && !esc_pend && free;

  always_comb begin
    load  = 1'b0;
    obyte = src;
    if (free) begin
      if (esc_pend) begin
        load  = 1'b1;
        obyte = esc_byte ^ OCT_XMASK;
      end else begin
        case (st)
          TX_IDLE:  begin load = in_valid; obyte = OCT_FLAG; end
          TX_CLOSE: begin load = 1'b1;     obyte = OCT_FLAG; end
          default:  begin
            load  = src_avail;
            obyte = needs_esc(src) ? OCT_ESC : src;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      crc      <= CRC_INIT;
      esc_pend <= 1'b0;
      esc_byte <= '0;
      esc_next <= TX_IDLE;
    end else if (free) begin
      if (esc_pend) begin
        esc_pend <= 1'b0;
        st       <= esc_next;
      end else begin
        case (st)
          TX_IDLE: if (in_valid) begin
            st  <= TX_BODY;
            crc <= CRC_INIT;
          end
          TX_CLOSE: st <= TX_IDLE;
          default: if (src_avail) begin
            if (st == TX_BODY) crc <= crc_next(crc, in_data);
            if (needs_esc(src)) begin
              esc_pend <= 1'b1;
              esc_byte <= src;
              esc_next <= after;
            end else begin
              st <= after;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ahdlc_rx.sv
module ahdlc_rx
  import ahdlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OCT_W-1:0] cfg_addr,
  input  logic             cfg_fcs_pass,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [OCT_W-1:0] out_data,
  output logic             out_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             stat_valid,
  output logic             stat_ok
);
  localparam int HOLD = FCS_BYTES + 1;
  localparam int CW   = $clog2(HOLD + 1);
  localparam int FW   = $clog2(HOLD);
  localparam logic [CW-1:0] CNT_FULL = CW'(HOLD);
  localparam logic [FW-1:0] IDX_TOP  = FW'(HOLD - 1);

  rx_st_t           st;
  logic             esc, fok, free, load, olast, take, is_flag, is_esc, addr_bad, data_take;
  logic [CW-1:0]    cnt;
  logic [FW-1:0]    fidx, fstop;
  logic [15:0]      crc;
  logic [OCT_W-1:0] hold [HOLD];
  logic [OCT_W-1:0] odata, dec;
  logic [OCT_W:0]   oword;

  ahdlc_oreg #(.W(OCT_W + 1)) u_oreg (
    .clk(clk), .rst(rst), .load(load), .din({olast, odata}), .ready(out_ready),
    .valid(out_valid), .dout(oword), .free(free)
  );
  assign out_last = oword[OCT_W];
  assign out_data = oword[OCT_W-1:0];

  assign in_ready  = free && (st != RX_FLUSH);
  assign take      = in_valid && in_ready;
  assign is_flag   = (in_data == OCT_FLAG);
  assign is_esc    = (in_data == OCT_ESC);
  assign dec       = esc ? (in_data ^ OCT_XMASK) : in_data;
  assign addr_bad  = (dec != cfg_addr) && (dec != OCT_BCAST);
  assign data_take = take && (st == RX_FRAME) && !is_flag && !is_esc;

  always_comb begin
    load  = 1'b0;
    odata = hold[HOLD-1];
    olast = 1'b0;
    if (st == RX_FLUSH) begin
      load  = free;
      odata = hold[fidx];
      olast = (fidx == fstop);
    end else if (data_take && (cnt == CNT_FULL)) begin
      load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_HUNT;
      esc        <= 1'b0;
      cnt        <= '0;
      crc        <= CRC_INIT;
      fidx       <= '0;
      fstop      <= '0;
      fok        <= 1'b0;
      stat_valid <= 1'b0;
      stat_ok    <= 1'b0;
      for (int k = 0; k < HOLD; k++) hold[k] <= '0;
    end else begin
      stat_valid <= 1'b0;
      case (st)
        RX_HUNT, RX_DROP: if (take && is_flag) begin
          st  <= RX_FRAME;
          esc <= 1'b0;
          cnt <= '0;
          crc <= CRC_INIT;
        end
        RX_FRAME: if (take) begin
          if (is_flag) begin
            esc <= 1'b0;
            cnt <= '0;
            crc <= CRC_INIT;
            if (esc) begin
              stat_valid <= 1'b1;
              stat_ok    <= 1'b0;
            end else if (cnt == CNT_FULL) begin
              st    <= RX_FLUSH;
              fidx  <= IDX_TOP;
              fstop <= cfg_fcs_pass ? '0 : IDX_TOP;
              fok   <= (crc == CRC_GOOD);
            end else if (cnt != '0) begin
              stat_valid <= 1'b1;
              stat_ok    <= 1'b0;
            end
          end else if (is_esc) begin
            esc <= 1'b1;
          end else begin
            esc <= 1'b0;
            crc <= crc_next(crc, dec);
            if ((cnt == '0) && addr_bad) begin
              st <= RX_DROP;
            end else begin
              hold[0] <= dec;
              for (int k = 1; k < HOLD; k++) hold[k] <= hold[k-1];
              if (cnt != CNT_FULL) cnt <= cnt + CW'(1);
            end
          end
        end
        RX_FLUSH: if (free) begin
          if (fidx == fstop) begin
            st         <= RX_FRAME;
            stat_valid <= 1'b1;
            stat_ok    <= fok;
          end else begin
            fidx <= fidx - FW'(1);
          end
        end
        default: st <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/ahdlc_engine.sv
module ahdlc_engine
  import ahdlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OCT_W-1:0] cfg_addr,
  input  logic             cfg_fcs_pass,
  input  logic [OCT_W-1:0] tx_in_data,
  input  logic             tx_in_valid,
  input  logic             tx_in_last,
  output logic             tx_in_ready,
  output logic [OCT_W-1:0] tx_out_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  input  logic [OCT_W-1:0] rx_in_data,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  output logic [OCT_W-1:0] rx_out_data,
  output logic             rx_out_last,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic             rx_stat_valid,
  output logic             rx_stat_ok
);
  ahdlc_tx u_tx (
    .clk(clk), .rst(rst),
    .in_data(tx_in_data), .in_valid(tx_in_valid), .in_last(tx_in_last), .in_ready(tx_in_ready),
    .out_data(tx_out_data), .out_valid(tx_out_valid), .out_ready(tx_out_ready)
  );

  ahdlc_rx u_rx (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_fcs_pass(cfg_fcs_pass),
    .in_data(rx_in_data), .in_valid(rx_in_valid), .in_ready(rx_in_ready),
    .out_data(rx_out_data), .out_last(rx_out_last), .out_valid(rx_out_valid),
    .out_ready(rx_out_ready), .stat_valid(rx_stat_valid), .stat_ok(rx_stat_ok)
  );
endmodule

// File: rtl/ahdlc_engine_chk.sv
module ahdlc_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] tx_out_data,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic [7:0] rx_out_data,
  input logic       rx_out_last,
  input logic       rx_out_valid,
  input logic       rx_out_ready,
  input logic       rx_stat_valid
);
  logic after_esc;

  always_ff @(posedge clk) begin
    if (rst) after_esc <= 1'b0;
    else if (tx_out_valid && tx_out_ready) after_esc <= (tx_out_data == 8'h7D) && !after_esc;
  end

  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_out_valid && !rx_out_valid && !rx_stat_valid));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data) && $stable(rx_out_last)));

  // R2
  esc_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && tx_out_ready && after_esc) |-> (tx_out_data == 8'h5E || tx_out_data == 8'h5D));

  // R10
  stat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_stat_valid |=> !rx_stat_valid);
endmodule

bind ahdlc_engine ahdlc_engine_chk u_chk (
  .clk(clk), .rst(rst),
  .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .rx_out_data(rx_out_data), .rx_out_last(rx_out_last), .rx_out_valid(rx_out_valid),
  .rx_out_ready(rx_out_ready), .rx_stat_valid(rx_stat_valid)
);

// File: tb/ahdlc_engine_tb.sv
module ahdlc_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MY_ADDR = 8'h42;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] cfg_addr = MY_ADDR;
  logic cfg_fcs_pass = 1'b0;
  logic [7:0] tx_in_data = '0; logic tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_in_ready;
  logic [7:0] tx_out_data; logic tx_out_valid, tx_out_ready = 1'b1;
  logic [7:0] rx_in_data = '0; logic rx_in_valid = 1'b0, rx_in_ready;
  logic [7:0] rx_out_data; logic rx_out_last, rx_out_valid, rx_out_ready = 1'b1;
  logic rx_stat_valid, rx_stat_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahdlc_engine u_dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_fcs_pass(cfg_fcs_pass),
    .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last), .tx_in_ready(tx_in_ready),
    .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_out_data(rx_out_data), .rx_out_last(rx_out_last), .rx_out_valid(rx_out_valid),
    .rx_out_ready(rx_out_ready), .rx_stat_valid(rx_stat_valid), .rx_stat_ok(rx_stat_ok)
  );

  int n_run = 0, n_fail = 0;
  logic bp_tx = 1'b0, bp_rx = 1'b0;
  logic [7:0] lf = 8'h5A;
  logic [7:0] txq[$]; logic [8:0] rxq[$]; logic statq[$];
  logic [7:0] pl[$]; logic [7:0] enc[$]; logic [8:0] exp9[$]; logic exps[$];

  // ready patterns change at the falling edge, handshakes are sampled just after
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_out_ready = !bp_tx || lf[0];
    rx_out_ready = !bp_rx || lf[2];
    #1;
    if (!rst) begin
      if (tx_out_valid && tx_out_ready) txq.push_back(tx_out_data);
      if (rx_out_valid && rx_out_ready) rxq.push_back({rx_out_last, rx_out_data});
      if (rx_stat_valid) statq.push_back(rx_stat_ok);
    end
  end

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all R tags): actual=hung expected=complete");
    finish_up();
  end

  function automatic logic [15:0] b_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {8'h00, d};
    repeat (8) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
    return x;
  endfunction

  function automatic logic [15:0] pl_fcs();
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (pl[i]) c = b_crc(c, pl[i]);
    return ~c;
  endfunction

  task automatic put_esc(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin enc.push_back(8'h7D); enc.push_back(b ^ 8'h20); end
    else enc.push_back(b);
  endtask

  task automatic build_enc(input logic [15:0] fx);
    logic [15:0] f;
    f = pl_fcs() ^ fx;
    enc.delete();
    enc.push_back(8'h7E);
    foreach (pl[i]) put_esc(pl[i]);
    put_esc(f[7:0]);
    put_esc(f[15:8]);
    enc.push_back(8'h7E);
  endtask

  task automatic tx_put(input logic [7:0] b, input logic l);
    tx_in_data = b; tx_in_valid = 1'b1; tx_in_last = l;
    #1;
    while (!tx_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_last = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    rx_in_data = b; rx_in_valid = 1'b1;
    #1;
    while (!rx_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic run_tx(input string tag);
    int bad;
    txq.delete();
    foreach (pl[i]) tx_put(pl[i], i == pl.size() - 1);
    repeat (40) @(negedge clk);
    build_enc(16'h0000);
    n_run++;
    bad = (txq.size() != enc.size()) ? 0 : -1;
    if (bad < 0) foreach (enc[i]) if (bad < 0 && txq[i] != enc[i]) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s tx stream: len actual=%0d expected=%0d, byte %0d actual=%h expected=%h",
               tag, txq.size(), enc.size(), bad,
               (bad < txq.size()) ? txq[bad] : 8'hxx, (bad < enc.size()) ? enc[bad] : 8'hxx);
    end
  endtask

  task automatic send_and_check_rx(input string tag);
    int bad;
    rxq.delete(); statq.delete();
    foreach (enc[i]) rx_put(enc[i]);
    repeat (40) @(negedge clk);
    n_run++;
    bad = (rxq.size() != exp9.size()) ? 0 : -1;
    if (bad < 0) foreach (exp9[i]) if (bad < 0 && rxq[i] != exp9[i]) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s rx data: len actual=%0d expected=%0d, item %0d actual=%h expected=%h",
               tag, rxq.size(), exp9.size(), bad,
               (bad < rxq.size()) ? rxq[bad] : 9'hxxx, (bad < exp9.size()) ? exp9[bad] : 9'hxxx);
    end
    n_run++;
    if (statq.size() != exps.size() || (exps.size() != 0 && statq[0] != exps[0])) begin
      n_fail++;
      $display("FAIL %s rx status: count actual=%0d expected=%0d, ok actual=%0d expected=%0d",
               tag, statq.size(), exps.size(),
               (statq.size() != 0) ? statq[0] : 1'bx, (exps.size() != 0) ? exps[0] : 1'bx);
    end
  endtask

  initial begin
    logic [15:0] f;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R12: quiet after reset
    n_run++;
    if (tx_out_valid || rx_out_valid || rx_stat_valid || tx_in_ready) begin
      n_fail++;
      $display("FAIL R12 reset: actual tv=%0d rv=%0d sv=%0d tr=%0d expected all 0",
               tx_out_valid, rx_out_valid, rx_stat_valid, tx_in_ready);
    end
    @(negedge clk);

    // R1 R2 R3: every single-byte body, half of them under backpressure
    for (int b = 0; b < 256; b++) begin
      bp_tx = b[0];
      pl.delete(); pl.push_back(8'(b));
      run_tx("R1/R2/R3");
    end

    // R2 R4: longer bodies with reserved octets, backpressure on
    bp_tx = 1'b1;
    for (int n = 2; n < 10; n++) begin
      pl.delete();
      for (int k = 0; k < n; k++)
        pl.push_back((k == 1) ? 8'h7E : (k == 2) ? 8'h7D : 8'(n * 31 + k * 17));
      run_tx("R2/R4");
    end
    bp_tx = 1'b0;

    // R5 R7: every second byte through the receiver, check bytes stripped
    cfg_fcs_pass = 1'b0;
    for (int b = 0; b < 256; b++) begin
      bp_rx = b[1];
      pl.delete(); pl.push_back(MY_ADDR); pl.push_back(8'(b));
      build_enc(16'h0000);
      exp9.delete(); exp9.push_back({1'b0, MY_ADDR}); exp9.push_back({1'b1, 8'(b)});
      exps.delete(); exps.push_back(1'b1);
      send_and_check_rx("R5/R7");
    end

    // R8 R4: check bytes passed through, output stalled
    cfg_fcs_pass = 1'b1; bp_rx = 1'b1;
    for (int b = 0; b < 64; b++) begin
      pl.delete(); pl.push_back(MY_ADDR); pl.push_back(8'(b * 5));
      f = pl_fcs();
      build_enc(16'h0000);
      exp9.delete();
      exp9.push_back({1'b0, MY_ADDR}); exp9.push_back({1'b0, 8'(b * 5)});
      exp9.push_back({1'b0, f[7:0]});  exp9.push_back({1'b1, f[15:8]});
      exps.delete(); exps.push_back(1'b1);
      send_and_check_rx("R8");
    end
    cfg_fcs_pass = 1'b0; bp_rx = 1'b0;

    // R6: address filter over every first byte
    for (int a = 0; a < 256; a++) begin
      pl.delete(); pl.push_back(8'(a)); pl.push_back(8'h33);
      build_enc(16'h0000);
      exp9.delete(); exps.delete();
      if (8'(a) == MY_ADDR || a == 255) begin
        exp9.push_back({1'b0, 8'(a)}); exp9.push_back({1'b1, 8'h33});
        exps.push_back(1'b1);
      end
      send_and_check_rx("R6");
    end

    // R9: corrupted check byte
    pl.delete(); pl.push_back(MY_ADDR); pl.push_back(8'h11); pl.push_back(8'h22);
    build_enc(16'h0100);
    exp9.delete();
    exp9.push_back({1'b0, MY_ADDR}); exp9.push_back({1'b0, 8'h11}); exp9.push_back({1'b1, 8'h22});
    exps.delete(); exps.push_back(1'b0);
    send_and_check_rx("R9");

    // R10: short frames and adjacent flags
    enc.delete(); enc.push_back(8'h7E); enc.push_back(MY_ADDR); enc.push_back(8'h7E);
    exp9.delete(); exps.delete(); exps.push_back(1'b0);
    send_and_check_rx("R10 one byte");
    enc.delete(); enc.push_back(8'h7E); enc.push_back(MY_ADDR); enc.push_back(8'h55); enc.push_back(8'h7E);
    send_and_check_rx("R10 two bytes");
    enc.delete(); enc.push_back(8'h7E); enc.push_back(8'h7E);
    exps.delete();
    send_and_check_rx("R10 empty");

    // R11: abort after one byte has left the window, then resynchronize
    enc.delete();
    enc.push_back(8'h7E); enc.push_back(MY_ADDR); enc.push_back(8'h01); enc.push_back(8'h02);
    enc.push_back(8'h03); enc.push_back(8'h7D); enc.push_back(8'h7E);
    exp9.delete(); exp9.push_back({1'b0, MY_ADDR});
    exps.delete(); exps.push_back(1'b0);
    send_and_check_rx("R11 abort");
    pl.delete(); pl.push_back(MY_ADDR); pl.push_back(8'h9A);
    build_enc(16'h0000);
    exp9.delete(); exp9.push_back({1'b0, MY_ADDR}); exp9.push_back({1'b1, 8'h9A});
    exps.delete(); exps.push_back(1'b1);
    send_and_check_rx("R11 resync");

    // R5: escape of an ordinary byte (0x7D 0x31 decodes to 0x11)
    pl.delete(); pl.push_back(MY_ADDR); pl.push_back(8'h11);
    f = pl_fcs();
    enc.delete();
    enc.push_back(8'h7E); enc.push_back(MY_ADDR); enc.push_back(8'h7D); enc.push_back(8'h31);
    put_esc(f[7:0]); put_esc(f[15:8]); enc.push_back(8'h7E);
    exp9.delete(); exp9.push_back({1'b0, MY_ADDR}); exp9.push_back({1'b1, 8'h11});
    exps.delete(); exps.push_back(1'b1);
    send_and_check_rx("R5 ordinary escape");

    finish_up();
  end
endmodule